// File: doc/BRIEF.md
# One-Wire Touch Slot Engine

This block runs read/write time slots on an open-drain one-wire line and can chain eight of them into a touch-byte operation. Each slot has four steps:
- It pulls the line low for a short start pulse.
- It then either lets go of the line, to send a 1 or to open a read slot, or keeps holding it low, to send a 0.
- It samples the line at a fixed point in the slot.
- It releases the line and waits out a short recovery gap.

Bits leave least significant first.

A single working register serves both directions. Its bit 0 is the bit to send. When a sample is taken, the sampled value enters at the top of the register and the register moves right by one place. After eight slots the received byte sits where the transmitted byte was. To read a byte, send 0xFF and collect the result. To write a byte, send the data and ignore what comes back. Slot timing is counted in microsecond ticks derived from the clock frequency parameter. The line input passes through a two-flop synchronizer.

Top module: `onewire_touch`

## Requirements
- R1: After reset, busy, done and ow_drive_low are all 0.
- R2: A start seen while idle makes busy 1 from the next cycle, and every slot opens with ow_drive_low held at 1 for LOW_US microseconds (6 us by default).
- R3: From LOW_US until RELEASE_US (60 us) after the slot start, ow_drive_low equals the inverse of the bit being sent: 0 for a 1, 1 for a 0.
- R4: From RELEASE_US until the end of the slot, ow_drive_low is 0 for RECOVER_US (2 us), giving a slot length of 62 us. Whenever busy is 0, ow_drive_low is 0.
- R5: The line is sampled SAMPLE_US (25 us) after the slot start, through the two-flop synchronizer. The sampled bit enters rx_byte bit 7, and the earlier contents move one place toward bit 0.
- R6: With mode = 0, eight slots run back to back and send tx_byte starting from bit 0. At done, rx_byte holds the sampled bits with the first sample in bit 0. Sending 0xFF returns the device's byte, and a write returns the sent bits wherever the line stayed released.
- R7: With mode = 1, exactly one slot runs, sending tx_byte bit 0. At done, rx_byte[7] is the sample and rx_byte[6:0] is tx_byte[7:1].
- R8: done is a one-cycle pulse in the first cycle that busy is 0 after an operation.
- R9: A start seen while busy is ignored. It does not change the timing, the bits sent or rx_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 1 | 0: full byte, 1: single bit |
| tx_byte | input | 8 | Data to send, bit 0 first |
| rx_byte | output | 8 | Working register; holds the received data at done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ow_drive_low | output | 1 | 1 pulls the line low; 0 releases it |
| ow_in | input | 1 | Raw line level |

## Verification
A phase register or microsecond counter that slips shows up on ow_drive_low within one slot. It appears as an edge at the wrong cycle, compared against a cycle-exact model on every clock. A wrong slot count is seen on busy and done at the end of the operation. A bad shift or a bad sample point is seen in rx_byte when done pulses. A start accepted while busy shows at once as a restarted low pulse on ow_drive_low.

// File: rtl/owt_pkg.sv
package owt_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_DATA, PH_REC} owt_phase_e;

  function automatic int cycles_per_us(input int hz);
    return (hz / 1000000 < 1) ? 1 : hz / 1000000;
  endfunction

  function automatic int slots_for_mode(input logic single, input int width);
    return single ? 1 : width;
  endfunction

  function automatic logic drive_for(input owt_phase_e ph, input logic bit_q);
    case (ph)
      PH_LOW:  return 1'b1;
      PH_DATA: return ~bit_q;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/owt_sync.sv
module owt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1, s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end
  assign q = s2;
endmodule

// File: rtl/owt_us_tick.sv
module owt_us_tick #(
  parameter int CPU = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (CPU > 1) ? $clog2(CPU) : 1;
  localparam logic [CW-1:0] LAST = CW'(CPU - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // R2
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/owt_slot_timer.sv
module owt_slot_timer
  import owt_pkg::*;
#(
  parameter int LOW_US     = 6,
  parameter int SAMPLE_US  = 25,
  parameter int RELEASE_US = 60,
  parameter int RECOVER_US = 2,
  parameter int DW         = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_acc,
  input  logic       single,
  input  logic       tick,
  output owt_phase_e phase,
  output logic       data_ev,
  output logic       sample_ev,
  output logic       done
);
  localparam int TOTAL_US = RELEASE_US + RECOVER_US;
  localparam int UW = $clog2(TOTAL_US + 1);
  localparam int LW = $clog2(DW + 1);
  localparam logic [UW-1:0] US_LOW  = UW'(LOW_US - 1);
  localparam logic [UW-1:0] US_SMP  = UW'(SAMPLE_US - 1);
  localparam logic [UW-1:0] US_REL  = UW'(RELEASE_US - 1);
  localparam logic [UW-1:0] US_END  = UW'(TOTAL_US - 1);

  logic [UW-1:0] us_q;
  logic [LW-1:0] left_q;
  logic          slot_end;

  assign slot_end  = tick && (phase != PH_IDLE) && (us_q == US_END);
  assign data_ev   = tick && (phase == PH_LOW)  && (us_q == US_LOW);
  assign sample_ev = tick && (phase == PH_DATA) && (us_q == US_SMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      us_q   <= '0;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start_acc) begin
          phase  <= PH_LOW;
          us_q   <= '0;
          left_q <= LW'(slots_for_mode(single, DW));
        end
      end else if (tick) begin
        if (slot_end) begin
          us_q <= '0;
          if (left_q == LW'(1)) begin
            phase  <= PH_IDLE;
            left_q <= '0;
            done   <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
            phase  <= PH_LOW;
          end
        end else begin
          us_q <= us_q + 1'b1;
          if (data_ev)                                phase <= PH_DATA;
          else if (phase == PH_DATA && us_q == US_REL) phase <= PH_REC;
        end
      end
    end
  end

  // R6
  slot_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= LW'(DW));
  // R4
  us_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    us_q <= US_END);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !slot_end) |=> (left_q == $past(left_q)));
endmodule

// File: rtl/owt_shift.sv
module owt_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          data_ev,
  input  logic          sample_ev,
  input  logic          smp,
  output logic          bit_q,
  output logic [DW-1:0] sr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      bit_q <= 1'b1;
    end else begin
      if (load)           sr <= load_val;
      else if (sample_ev) sr <= {smp, sr[DW-1:1]};
      if (data_ev)        bit_q <= sr[0];
    end
  end

  // R5
  sample_enters_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ev && !load) |=> (sr[DW-1] == $past(smp)) && (sr[DW-2:0] == $past(sr[DW-1:1])));
endmodule

// File: rtl/onewire_touch.sv
module onewire_touch
  import owt_pkg::*;
#(
  parameter int CLK_HZ     = 50000000,
  parameter int LOW_US     = 6,
  parameter int SAMPLE_US  = 25,
  parameter int RELEASE_US = 60,
  parameter int RECOVER_US = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       done,
  output logic       ow_drive_low,
  input  logic       ow_in
);
  localparam int DW  = 8;
  localparam int CPU = cycles_per_us(CLK_HZ);

  owt_phase_e phase;
  logic start_acc, tick, data_ev, sample_ev, line_s, bit_q;

  assign busy      = (phase != PH_IDLE);
  assign start_acc = start && !busy;

  owt_sync u_sync (.clk(clk), .rst_n(rst_n), .d(ow_in), .q(line_s));

  owt_us_tick #(.CPU(CPU)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  owt_slot_timer #(
    .LOW_US(LOW_US), .SAMPLE_US(SAMPLE_US), .RELEASE_US(RELEASE_US),
    .RECOVER_US(RECOVER_US), .DW(DW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .single(mode),
    .tick(tick), .phase(phase), .data_ev(data_ev), .sample_ev(sample_ev),
    .done(done)
  );

  owt_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .load_val(tx_byte),
    .data_ev(data_ev), .sample_ev(sample_ev), .smp(line_s),
    .bit_q(bit_q), .sr(rx_byte)
  );

  assign ow_drive_low = drive_for(phase, bit_q);

  // R4
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ow_drive_low);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && ow_drive_low));
endmodule

// File: tb/tb_onewire_touch.sv
module tb_onewire_touch;
  localparam int CPU  = 50;
  localparam int SLOT = 62 * CPU;
  localparam int LOWC = 6 * CPU;
  localparam int RELC = 60 * CPU;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic busy, done, ow_drive_low, dev_low = 1'b0;
  logic ow_in;
  int total_n = 0, bad_n = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign ow_in = ~(ow_drive_low | dev_low);

  onewire_touch dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .busy(busy), .done(done), .ow_drive_low(ow_drive_low),
    .ow_in(ow_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_op(input logic m, input logic [7:0] tx, input logic [7:0] resp, input bit poke);
    int n = m ? 1 : 8;
    int tot = n * SLOT;
    logic [7:0] exp_rx;
    exp_rx = m ? {tx[0] & resp[0], tx[7:1]} : (tx & resp);
    @(negedge clk);
    mode = m; tx_byte = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= tot; c++) begin
      int s = c / SLOT;
      int off = c % SLOT;
      logic b, edl;
      b = (s < 8) ? tx[s] : 1'b1;
      dev_low = (c < tot) ? ~resp[s] : 1'b0;
      edl = (c < tot) && ((off < LOWC) || ((off < RELC) && !b));
      chk(busy == (c < tot), "R2 busy", busy, c < tot);
      if (off < LOWC) chk(ow_drive_low == edl, "R2 start low", ow_drive_low, edl);
      else if (off < RELC) chk(ow_drive_low == edl, "R3 data bit", ow_drive_low, edl);
      else chk(ow_drive_low == edl, "R4 release", ow_drive_low, edl);
      chk(done == (c == tot), "R8 done", done, c == tot);
      if (c == tot) begin
        if (m) chk(rx_byte == exp_rx, "R7 single rx", rx_byte, exp_rx);
        else   chk(rx_byte == exp_rx, "R6 byte rx", rx_byte, exp_rx);
        if (poke) chk(rx_byte == exp_rx, "R9 ignored start", rx_byte, exp_rx);
      end
      if (poke && (c == tot / 2 || c == SLOT + 5)) begin
        start = 1'b1; mode = ~m; tx_byte = ~tx;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    dev_low = 1'b0;
    chk(busy == 1'b0 && done == 1'b0, "R8 after done", {busy, done}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad_n++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(ow_drive_low == 0, "R1 line", ow_drive_low, 0);
    // R6 read: send all ones, device answers A5
    run_op(1'b0, 8'hFF, 8'hA5, 1'b0);
    // R6 write: device silent, reply equals data
    run_op(1'b0, 8'h3C, 8'hFF, 1'b0);
    // R5 mixed pattern with R9 starts while busy
    run_op(1'b0, 8'h5A, 8'h0F, 1'b1);
    // R7 single-bit slots
    run_op(1'b1, 8'hB3, 8'h00, 1'b0);
    run_op(1'b1, 8'h81, 8'hFF, 1'b1);
    run_op(1'b1, 8'h40, 8'hFF, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end
endmodule